// File: doc/BRIEF.md
# Regulator Overvoltage Latch and Power-Good Supervisor

This block watches a voltage regulator's output through a set of digital comparator flags. It drives the power-good indication and the mode of the PWM outputs. The flags are: output above the overvoltage trip, output below the undervoltage level (half of the VID), differential sense below its low level, and overcurrent. The block also picks the overvoltage trip reference. The reference stays at the fixed pre-VID level until a valid VID has been seen while the regulator is enabled. After that it moves to the VID-relative level.

Overvoltage protection runs from reset onward, whether the regulator is enabled or not. When an overvoltage appears, the PWM outputs are commanded low in the same cycle and the fault is latched. The outputs stay low until the overvoltage has gone and the differential sense has dropped below its low level. The outputs then float. If the overvoltage returns, the pull-low repeats. Only reset or a fresh rising edge of the enable clears the latch. Changes to the VID inputs never clear it. Power-good rises only after soft-start is done and every health condition has held for a fixed delay, 85 µs by default, which is converted to clock cycles from the clock frequency parameter. Power-good drops at once on any bad condition.

All pins are plain control and status levels. No stream passes through the block, so no valid/ready handshake and no back-pressure apply.

Top module: `ovp_pgood_ctrl`

## Requirements
- R1: `ovp_thr_sel` is 0 (fixed reference) until `vid_valid` is sampled high at a clock edge while `enable` is high. It is then 1 (VID-relative reference) from that edge on. It returns to 0 after any edge at which `enable` is sampled low.
- R2: While `ov_above` is high, `pwm_mode` is FORCE_LOW (2'b01) in the same cycle, in every state and whatever `enable` is. The fault latches at the next edge, and `ov_fault` reads 1.
- R3: A latched fault in the drive-low phase keeps `pwm_mode` at FORCE_LOW until an edge where `ov_above` is low and `vdiff_low` is high. From that edge on, `pwm_mode` is HIGH_Z (2'b10).
- R4: In the high-impedance phase, a recurring `ov_above` returns `pwm_mode` to FORCE_LOW in the same cycle and re-enters the drive-low phase at the next edge.
- R5: A latched fault (`ov_fault` = 1) is cleared only by `rst_n` low or by a rising `enable` (sampled low at one edge, high at the next). Activity on `vid_valid` and `vid_off` has no effect on it. At a clearing edge where `ov_above` is high, the fault re-latches.
- R6: With no latched fault and `ov_above` low, `pwm_mode` is NORMAL (2'b00) when `enable` is high and `vid_off` is low, and HIGH_Z otherwise.
- R7: The health condition is: `enable`, `ss_done`, no `vid_off`, no latched fault, and none of `ov_above`, `uv_below`, `oc_trip`. When it is sampled true at DLY consecutive edges, `pgood` goes high after the DLY-th edge and not before. DLY = CLK_FREQ_KHZ*DELAY_US/1000.
- R8: `pgood` is low in the same cycle that the health condition fails, and the delay count restarts from zero.
- R9: After reset, `pwm_mode` is HIGH_Z, and `pgood`, `ovp_thr_sel` and `ov_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Regulator enable (combined enable pins) |
| vid_valid | input | 1 | A valid VID code is present |
| vid_off | input | 1 | VID off-code is present |
| ss_done | input | 1 | Soft-start ramp has reached the target |
| ov_above | input | 1 | Output above the overvoltage trip |
| uv_below | input | 1 | Output below half of the VID |
| vdiff_low | input | 1 | Differential sense below its low level |
| oc_trip | input | 1 | Overcurrent comparator tripped |
| ovp_thr_sel | output | 1 | 0 = fixed reference, 1 = VID-relative reference |
| pwm_mode | output | 2 | 00 NORMAL, 01 FORCE_LOW, 10 HIGH_Z |
| pgood | output | 1 | Power-good indication |
| ov_fault | output | 1 | Overvoltage fault latched |

## Verification
The bench targets the repeat of the pull-low after the outputs have floated. A design that wrongly treats the fault as one-shot would leave the outputs floating during a second overvoltage. It also cycles the VID inputs during a latched fault: a design that clears on VID activity would return to NORMAL. The bench checks the power-good delay at the exact edge where it should rise. An off-by-one counter shows up one cycle early or late. It also injects single-cycle undervoltage and overcurrent glitches during the count, which a design that does not restart the count would miss. Random phases that mix quiet and noisy inputs, including enable toggles while a fault is latched, are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    PWM_NORMAL = 2'b00,
    PWM_LOW    = 2'b01,
    PWM_HIZ    = 2'b10
  } pwm_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_DRIVELOW = 2'b01,
    FLT_RELEASED = 2'b10
  } flt_state_e;
endpackage

// File: rtl/ovp_thr_select.sv
module ovp_thr_select (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic vid_valid,
  output logic thr_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr_sel <= 1'b0;
    else if (!enable) thr_sel <= 1'b0;
    else if (vid_valid) thr_sel <= 1'b1;
  end

  assert_thr_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !thr_sel);
  assert_thr_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && vid_valid) |=> thr_sel);
endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch
  import ovp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rise,
  input  logic       ov_above,
  input  logic       vdiff_low,
  output flt_state_e state
);
  flt_state_e nxt;

  always_comb begin
    nxt = state;
    if (en_rise) begin
      nxt = ov_above ? FLT_DRIVELOW : FLT_NONE;
    end else begin
      unique case (state)
        FLT_NONE:     if (ov_above) nxt = FLT_DRIVELOW;
        FLT_DRIVELOW: if (!ov_above && vdiff_low) nxt = FLT_RELEASED;
        FLT_RELEASED: if (ov_above) nxt = FLT_DRIVELOW;
        default:      nxt = FLT_DRIVELOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FLT_NONE;
    else        state <= nxt;
  end

  assert_ov_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_above |=> state == FLT_DRIVELOW);
  assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FLT_DRIVELOW && !vdiff_low && !en_rise) |=> state == FLT_DRIVELOW);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != FLT_NONE && !en_rise) |=> state != FLT_NONE);
  assert_legal_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11);
endmodule

// File: rtl/pgood_timer.sv
module pgood_timer #(
  parameter int unsigned DLY = 21250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic healthy,
  output logic pgood
);
  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIM  = CW'(DLY);
  localparam logic [CW-1:0] LIM1 = CW'(DLY - 1);

  logic [CW-1:0] cnt;
  logic          pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pg_q <= 1'b0;
    end else if (!healthy) begin
      cnt  <= '0;
      pg_q <= 1'b0;
    end else begin
      if (cnt != LIM) cnt <= cnt + 1'b1;
      pg_q <= (cnt >= LIM1);
    end
  end

  assign pgood = pg_q & healthy;

  assert_rise_needs_health_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(healthy));
  assert_drop_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !healthy |=> (cnt == '0 && !pg_q));
endmodule

// File: rtl/ovp_pgood_ctrl.sv
module ovp_pgood_ctrl
  import ovp_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ = 250000,
  parameter int unsigned DELAY_US     = 85
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       vid_valid,
  input  logic       vid_off,
  input  logic       ss_done,
  input  logic       ov_above,
  input  logic       uv_below,
  input  logic       vdiff_low,
  input  logic       oc_trip,
  output logic       ovp_thr_sel,
  output logic [1:0] pwm_mode,
  output logic       pgood,
  output logic       ov_fault
);
  localparam int unsigned DLY_RAW = CLK_FREQ_KHZ * DELAY_US / 1000;
  localparam int unsigned DLY     = (DLY_RAW < 1) ? 1 : DLY_RAW;

  logic       en_q;
  logic       en_rise;
  logic       healthy;
  flt_state_e fst;
  pwm_mode_e  mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end
  assign en_rise = enable & ~en_q;

  ovp_thr_select u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .vid_valid (vid_valid),
    .thr_sel   (ovp_thr_sel)
  );

  ovp_fault_latch u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_rise   (en_rise),
    .ov_above  (ov_above),
    .vdiff_low (vdiff_low),
    .state     (fst)
  );

  always_comb begin
    if (ov_above || fst == FLT_DRIVELOW) mode = PWM_LOW;
    else if (fst == FLT_RELEASED)        mode = PWM_HIZ;
    else if (enable && !vid_off)         mode = PWM_NORMAL;
    else                                 mode = PWM_HIZ;
  end
  assign pwm_mode = mode;
  assign ov_fault = (fst != FLT_NONE);

  assign healthy = enable & ss_done & ~vid_off & (fst == FLT_NONE)
                 & ~ov_above & ~uv_below & ~oc_trip;

  pgood_timer #(.DLY(DLY)) u_pg (
    .clk     (clk),
    .rst_n   (rst_n),
    .healthy (healthy),
    .pgood   (pgood)
  );

  assert_ov_forces_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ov_above |-> pwm_mode == PWM_LOW);
  assert_pgood_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (pwm_mode == PWM_NORMAL && !ov_fault));
  assert_flag_matches_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov_fault && !ov_above && enable && !vid_off) |-> pwm_mode == PWM_NORMAL);
endmodule

// File: tb/test_ovp_pgood_ctrl.sv
`timescale 1ns/1ps
module test_ovp_pgood_ctrl;
  localparam int unsigned DLY = 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 0, vid_valid = 0, vid_off = 0, ss_done = 0;
  logic ov_above = 0, uv_below = 0, vdiff_low = 0, oc_trip = 0;
  logic ovp_thr_sel, pgood, ov_fault;
  logic [1:0] pwm_mode;

  int total = 0, bad = 0;
  bit done = 0;

  int m_flt = 0, m_cnt = 0;
  bit m_en_q = 0, m_thr = 0, m_pg = 0;

  always #2 clk = ~clk;

  ovp_pgood_ctrl #(.CLK_FREQ_KHZ(250000), .DELAY_US(1)) i_ovp_pgood_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vid_valid(vid_valid),
    .vid_off(vid_off), .ss_done(ss_done), .ov_above(ov_above),
    .uv_below(uv_below), .vdiff_low(vdiff_low), .oc_trip(oc_trip),
    .ovp_thr_sel(ovp_thr_sel), .pwm_mode(pwm_mode), .pgood(pgood),
    .ov_fault(ov_fault));

  function automatic logic [1:0] exp_mode(int flt, bit en, bit voff, bit ov);
    if (ov || flt == 1) return 2'b01;
    if (flt == 2) return 2'b10;
    return (en && !voff) ? 2'b00 : 2'b10;
  endfunction

  function automatic bit exp_ok(int flt, bit en, bit voff, bit ss, bit ov, bit uv, bit oc);
    return en && ss && !voff && flt == 0 && !ov && !uv && !oc;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs at mid-cycle, then advance the model through the next edge
  task automatic step();
    bit ok;
    logic [1:0] em;
    #1;
    ok = exp_ok(m_flt, enable, vid_off, ss_done, ov_above, uv_below, oc_trip);
    em = exp_mode(m_flt, enable, vid_off, ov_above);
    chk(ov_above ? "R2 mode" : (m_flt == 1 ? "R3 mode" : (m_flt == 2 ? "R4 mode" : "R6 mode")),
        pwm_mode, em);
    chk((m_pg && ok) ? "R7 pgood" : "R8 pgood", pgood, m_pg && ok);
    chk("R1 thr_sel", ovp_thr_sel, m_thr);
    chk("R5 ov_fault", ov_fault, m_flt != 0);
    if (enable && !m_en_q) m_flt = ov_above ? 1 : 0;
    else case (m_flt)
      0: if (ov_above) m_flt = 1;
      1: if (!ov_above && vdiff_low) m_flt = 2;
      default: if (ov_above) m_flt = 1;
    endcase
    m_en_q = enable;
    m_thr = enable ? (m_thr | vid_valid) : 1'b0;
    if (!ok) begin m_cnt = 0; m_pg = 0; end
    else begin
      m_pg = (m_cnt >= DLY - 1);
      if (m_cnt != DLY) m_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    enable = 1; ss_done = 1; vid_off = 0; ov_above = 0; uv_below = 0;
    oc_trip = 0; vdiff_low = 0; vid_valid = 1;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk); @(negedge clk);
    // R9: reset state
    chk("R9 mode", pwm_mode, 2'b10);
    chk("R9 pgood", pgood, 0);
    chk("R9 thr", ovp_thr_sel, 0);
    chk("R9 fault", ov_fault, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 while disabled: ov latches even with enable low
    ov_above = 1; step();
    ov_above = 0; vdiff_low = 1; step(); step();
    // R5 enable rise clears
    quiet(); step();
    // R7 exact delay edge
    for (int i = 0; i < DLY - 1; i++) step();
    chk("R7 pgood early", pgood, 0);
    step();
    chk("R7 pgood at delay", pgood, 1);
    // R8 single-cycle uv and oc glitches restart count
    uv_below = 1; step(); uv_below = 0;
    for (int i = 0; i < DLY / 2; i++) step();
    oc_trip = 1; step(); oc_trip = 0;
    for (int i = 0; i < DLY + 2; i++) step();
    // R3/R4 latch, release, recurrence
    ov_above = 1; step(); step();
    ov_above = 0; vdiff_low = 0; step(); step();
    vdiff_low = 1; step(); step();
    chk("R3 released mode", pwm_mode, 2'b10);
    ov_above = 1; step();
    ov_above = 0; step(); step();
    // R5 vid activity does not clear
    for (int i = 0; i < 20; i++) begin
      vid_valid = i[0]; vid_off = i[1]; step();
    end
    chk("R5 still latched", ov_fault, 1);
    vid_off = 0;
    enable = 0; step(); enable = 1; step();
    chk("R5 cleared by enable cycle", ov_fault, 0);
    chk("R6 normal after clear", pwm_mode, 2'b00);

    // random phases: quiet stretches alternating with noisy ones
    for (int ph = 0; ph < 10; ph++) begin
      for (int c = 0; c < 400; c++) begin
        if (ph % 2 == 0) begin
          quiet();
          vid_valid = ($urandom % 4) == 0;
          if (c == 0) enable = 0;
        end else begin
          ov_above  = ($urandom % 40) == 0;
          uv_below  = ($urandom % 20) == 0;
          oc_trip   = ($urandom % 50) == 0;
          vdiff_low = ($urandom % 2) == 0;
          vid_valid = ($urandom % 3) == 0;
          vid_off   = ($urandom % 60) == 0;
          ss_done   = ($urandom % 10) != 0;
          if (($urandom % 100) == 0) enable = ~enable;
        end
        step();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule